// File: doc/BRIEF.md
# Group Timer with Snapshot Readout

A general-purpose timer built around a 54-bit up/down counter. A programmable prescaler paces the counter, and a magnitude comparator raises an interrupt when the count reaches a programmed target. Software reaches everything through a 32-bit register port with byte addresses. Only address bits above bit 1 are decoded. Reads are combinational from `rd_addr`, and writes take effect at the clock edge where `wr_en` is high.

A read of the count is made coherent by a write-triggered capture. Software writes the capture register, then reads the two captured words at its leisure. A new count is staged first and then committed by a separate trigger. The same staged value serves as the reload value when an alarm fires with auto-reload set. The alarm disarms itself when it fires, so each arming produces exactly one event.

Top module: `snap_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The count is 54 bits wide. Word 0x04 reads count bits 31:0 of the capture. Word 0x08 reads count bits 53:32 in bits 21:0, and its bits 31:22 always read 0.
- R3: A write of any value to 0x0C copies the live count into the capture, taken from the value the count held in the cycle of the write. Reads of 0x04/0x08 stay unchanged until the next such write.
- R4: Writes to 0x10 (low word) and 0x14 (bits 21:0 = high part) only stage a value and leave the count untouched. A write of any value to 0x18 makes the count equal the staged value on the next edge.
- R5: Control word 0x00 bits 31:16 hold a divider N. While running, the count steps once every N clocks, and N = 0 divides by 65536. The divider phase restarts whenever counting is stopped.
- R6: Control bit 0 enables counting and bit 1 selects the direction (1 = up, 0 = down). The count wraps modulo 2^54 in both directions.
- R7: The alarm target sits at 0x1C (bits 31:0) and 0x20 (bits 21:0). When counting up, a match means count >= target; when counting down, count <= target. A target already passed therefore fires on the next edge.
- R8: The alarm fires only while control bit 3 (arm) is set. Firing clears the arm bit.
- R9: If control bit 2 (auto-reload) is set when the alarm fires, the count takes the staged value on that edge instead of stepping.
- R10: Firing sets a raw flag, read at bit 0 of 0x30. Bit 0 of 0x24 enables the interrupt. Bit 0 of 0x2C and the `irq` pin both show raw AND enable. Writing 1 to bit 0 of 0x28 clears the raw flag, but a firing in the same cycle wins.
- R11: While counting is disabled, the count holds its value except for a load or an auto-reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Interrupt, raw alarm flag gated by enable |

## Verification
The hardest case to reach is an alarm that fires while the counter is running with auto-reload set. In that case the reload and the prescaler step compete on the same edge, and the final count depends on exactly which edge saw the match. The bench starts the counter, the arm bit and auto-reload in a single control write, with a divider of 1 and a known load value. It stops the counter after a fixed number of cycles, so the expected count after reload and resumed counting follows from edge arithmetic. Already-passed targets, equal targets and disarmed targets are driven with the counter stopped, so each firing edge is exact.

// File: rtl/snap_timer_pkg.sv
package snap_timer_pkg;
    // Word indices of the register file (byte address / 4)
    localparam int unsigned RG_CTRL      = 0;
    localparam int unsigned RG_CAP_LO    = 1;
    localparam int unsigned RG_CAP_HI    = 2;
    localparam int unsigned RG_CAP_TRIG  = 3;
    localparam int unsigned RG_STG_LO    = 4;
    localparam int unsigned RG_STG_HI    = 5;
    localparam int unsigned RG_LOAD_TRIG = 6;
    localparam int unsigned RG_TGT_LO    = 7;
    localparam int unsigned RG_TGT_HI    = 8;
    localparam int unsigned RG_IRQ_EN    = 9;
    localparam int unsigned RG_IRQ_CLR   = 10;
    localparam int unsigned RG_IRQ_STAT  = 11;
    localparam int unsigned RG_IRQ_RAW   = 12;

    // Control word bit positions
    localparam int unsigned CB_RUN    = 0;
    localparam int unsigned CB_UP     = 1;
    localparam int unsigned CB_RELOAD = 2;
    localparam int unsigned CB_ARM    = 3;
    localparam int unsigned CB_DIV    = 16;
endpackage

// File: rtl/snap_timer_prescale.sv
module snap_timer_prescale #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] divisor,
    output logic             tick
);
    logic [PRE_W-1:0] div_d, div_q;
    logic [PRE_W-1:0] last_phase;

    // divisor 0 wraps to all ones: a full 2^PRE_W division
    assign last_phase = divisor - PRE_W'(1);
    assign tick       = run && (div_q == last_phase);

    always_comb begin
        div_d = div_q;
        if (!run) begin
            div_d = '0;
        end else if (tick) begin
            div_d = '0;
        end else begin
            div_d = div_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/snap_timer_match.sv
module snap_timer_match #(
    parameter int CNT_W = 54
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] target,
    input  logic             up,
    input  logic             armed,
    output logic             hit
);
    logic reached;

    always_comb begin
        if (up) begin
            reached = (count >= target);
        end else begin
            reached = (count <= target);
        end
        hit = armed && reached;
    end
endmodule

// File: rtl/snap_timer.sv
module snap_timer
    import snap_timer_pkg::*;
#(
    parameter int CNT_W  = 54,
    parameter int PRE_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq
);
    localparam int HI_W   = CNT_W - 32;
    localparam int WORD_W = ADDR_W - 2;

    localparam logic [WORD_W-1:0] W_CTRL      = WORD_W'(RG_CTRL);
    localparam logic [WORD_W-1:0] W_CAP_LO    = WORD_W'(RG_CAP_LO);
    localparam logic [WORD_W-1:0] W_CAP_HI    = WORD_W'(RG_CAP_HI);
    localparam logic [WORD_W-1:0] W_CAP_TRIG  = WORD_W'(RG_CAP_TRIG);
    localparam logic [WORD_W-1:0] W_STG_LO    = WORD_W'(RG_STG_LO);
    localparam logic [WORD_W-1:0] W_STG_HI    = WORD_W'(RG_STG_HI);
    localparam logic [WORD_W-1:0] W_LOAD_TRIG = WORD_W'(RG_LOAD_TRIG);
    localparam logic [WORD_W-1:0] W_TGT_LO    = WORD_W'(RG_TGT_LO);
    localparam logic [WORD_W-1:0] W_TGT_HI    = WORD_W'(RG_TGT_HI);
    localparam logic [WORD_W-1:0] W_IRQ_EN    = WORD_W'(RG_IRQ_EN);
    localparam logic [WORD_W-1:0] W_IRQ_CLR   = WORD_W'(RG_IRQ_CLR);
    localparam logic [WORD_W-1:0] W_IRQ_STAT  = WORD_W'(RG_IRQ_STAT);
    localparam logic [WORD_W-1:0] W_IRQ_RAW   = WORD_W'(RG_IRQ_RAW);

    typedef struct packed {
        logic             run;
        logic             up;
        logic             reload;
        logic             arm;
        logic [PRE_W-1:0] divisor;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] capture;
        logic [CNT_W-1:0] staged;
        logic [CNT_W-1:0] target;
        logic             irq_en;
        logic             raw;
    } state_t;

    state_t s_d, s_q;

    logic [WORD_W-1:0] wr_word, rd_word;
    logic              step;
    logic              alarm_hit;

    // plain views of state for the bound checker
    logic [CNT_W-1:0] count_q, staged_q, capture_q;
    logic             arm_q, raw_q, irq_en_q, run_q, reload_q;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{wr_addr[1:0], rd_addr[1:0]};

    assign wr_word = wr_addr[ADDR_W-1:2];
    assign rd_word = rd_addr[ADDR_W-1:2];

    snap_timer_prescale #(.PRE_W(PRE_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.run),
        .divisor (s_q.divisor),
        .tick    (step)
    );

    snap_timer_match #(.CNT_W(CNT_W)) u_match (
        .count  (s_q.count),
        .target (s_q.target),
        .up     (s_q.up),
        .armed  (s_q.arm),
        .hit    (alarm_hit)
    );

    always_comb begin
        s_d = s_q;

        if (step) begin
            if (s_q.up) begin
                s_d.count = s_q.count + CNT_W'(1);
            end else begin
                s_d.count = s_q.count - CNT_W'(1);
            end
        end

        if (alarm_hit) begin
            s_d.raw = 1'b1;
            s_d.arm = 1'b0;
            if (s_q.reload) begin
                s_d.count = s_q.staged;
            end
        end

        if (wr_en) begin
            case (wr_word)
                W_CTRL: begin
                    s_d.run     = wr_data[CB_RUN];
                    s_d.up      = wr_data[CB_UP];
                    s_d.reload  = wr_data[CB_RELOAD];
                    s_d.arm     = wr_data[CB_ARM];
                    s_d.divisor = wr_data[CB_DIV +: PRE_W];
                end
                W_CAP_TRIG:  s_d.capture = s_q.count;
                W_STG_LO:    s_d.staged[31:0] = wr_data;
                W_STG_HI:    s_d.staged[CNT_W-1:32] = wr_data[HI_W-1:0];
                W_LOAD_TRIG: s_d.count = s_q.staged;
                W_TGT_LO:    s_d.target[31:0] = wr_data;
                W_TGT_HI:    s_d.target[CNT_W-1:32] = wr_data[HI_W-1:0];
                W_IRQ_EN:    s_d.irq_en = wr_data[0];
                W_IRQ_CLR: begin
                    if (wr_data[0] && !alarm_hit) begin
                        s_d.raw = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_word)
            W_CTRL: begin
                rd_data[CB_RUN]          = s_q.run;
                rd_data[CB_UP]           = s_q.up;
                rd_data[CB_RELOAD]       = s_q.reload;
                rd_data[CB_ARM]          = s_q.arm;
                rd_data[CB_DIV +: PRE_W] = s_q.divisor;
            end
            W_CAP_LO:   rd_data = s_q.capture[31:0];
            W_CAP_HI:   rd_data[HI_W-1:0] = s_q.capture[CNT_W-1:32];
            W_STG_LO:   rd_data = s_q.staged[31:0];
            W_STG_HI:   rd_data[HI_W-1:0] = s_q.staged[CNT_W-1:32];
            W_TGT_LO:   rd_data = s_q.target[31:0];
            W_TGT_HI:   rd_data[HI_W-1:0] = s_q.target[CNT_W-1:32];
            W_IRQ_EN:   rd_data[0] = s_q.irq_en;
            W_IRQ_STAT: rd_data[0] = s_q.raw & s_q.irq_en;
            W_IRQ_RAW:  rd_data[0] = s_q.raw;
            default: ;
        endcase
    end

    assign irq = s_q.raw & s_q.irq_en;

    assign count_q   = s_q.count;
    assign staged_q  = s_q.staged;
    assign capture_q = s_q.capture;
    assign arm_q     = s_q.arm;
    assign raw_q     = s_q.raw;
    assign irq_en_q  = s_q.irq_en;
    assign run_q     = s_q.run;
    assign reload_q  = s_q.reload;
endmodule

// File: rtl/snap_timer_chk.sv
module snap_timer_chk
    import snap_timer_pkg::*;
#(
    parameter int CNT_W  = 54,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic              irq,
    input logic              alarm_hit,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  staged_q,
    input logic [CNT_W-1:0]  capture_q,
    input logic              arm_q,
    input logic              raw_q,
    input logic              irq_en_q,
    input logic              run_q,
    input logic              reload_q
);
    localparam int HI_W   = CNT_W - 32;
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] wr_word, rd_word;
    logic wr_ctrl, wr_cap, wr_load;

    assign wr_word = wr_addr[ADDR_W-1:2];
    assign rd_word = rd_addr[ADDR_W-1:2];
    assign wr_ctrl = wr_en && (wr_word == WORD_W'(RG_CTRL));
    assign wr_cap  = wr_en && (wr_word == WORD_W'(RG_CAP_TRIG));
    assign wr_load = wr_en && (wr_word == WORD_W'(RG_LOAD_TRIG));

    logic unused_chk_bits;
    assign unused_chk_bits = ^{wr_addr[1:0], rd_addr[1:0]};

    a_r2_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word == WORD_W'(RG_CAP_HI)) |-> (rd_data[31:HI_W] == '0));

    a_r3_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cap |=> $stable(capture_q));

    a_r3_capture_take: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cap |=> (capture_q == $past(count_q)));

    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (count_q == $past(staged_q)));

    a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hit && !wr_ctrl) |=> !arm_q);

    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hit && reload_q && !wr_load) |=> (count_q == $past(staged_q)));

    a_r10_raw_set: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> raw_q);

    a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_q && irq_en_q));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !alarm_hit && !wr_load) |=> $stable(count_q));
endmodule

bind snap_timer snap_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq       (irq),
    .alarm_hit (alarm_hit),
    .count_q   (count_q),
    .staged_q  (staged_q),
    .capture_q (capture_q),
    .arm_q     (arm_q),
    .raw_q     (raw_q),
    .irq_en_q  (irq_en_q),
    .run_q     (run_q),
    .reload_q  (reload_q)
);

// File: tb/snap_timer_bench.sv
`timescale 1ns/1ps
module snap_timer_bench;
    localparam logic [7:0] A_CTRL = 8'h00, A_CAP_LO = 8'h04, A_CAP_HI = 8'h08,
                           A_CAP_TRIG = 8'h0C, A_STG_LO = 8'h10, A_STG_HI = 8'h14,
                           A_LOAD = 8'h18, A_TGT_LO = 8'h1C, A_TGT_HI = 8'h20,
                           A_IRQ_EN = 8'h24, A_IRQ_CLR = 8'h28, A_IRQ_STAT = 8'h2C,
                           A_IRQ_RAW = 8'h30;
    localparam logic [53:0] MAX54 = {54{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    snap_timer u_snap_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [31:0] ctrl(bit run, bit up, bit rl, bit arm, logic [15:0] dv);
        return {dv, 12'd0, arm, rl, up, run};
    endfunction

    function automatic logic [53:0] exp_count(logic [53:0] start, bit up, int m, int dv);
        int steps = m / ((dv == 0) ? 65536 : dv);
        return up ? start + 54'(steps) : start - 54'(steps);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // call at a negedge; the write lands on the next posedge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic load(logic [53:0] v);
        wr(A_STG_LO, v[31:0]);
        wr(A_STG_HI, {10'd0, v[53:32]});
        wr(A_LOAD, 32'h0);
    endtask

    task automatic set_target(logic [53:0] v);
        wr(A_TGT_LO, v[31:0]);
        wr(A_TGT_HI, {10'd0, v[53:32]});
    endtask

    task automatic get_count(output logic [53:0] v);
        logic [31:0] lo, hi;
        wr(A_CAP_TRIG, 32'h5A5A);
        rd(A_CAP_LO, lo);
        rd(A_CAP_HI, hi);
        v = {hi[21:0], lo};
    endtask

    // starts counting on one edge and stops exactly m edges later
    task automatic run_for(logic [31:0] cword, int m);
        wr(A_CTRL, cword);
        repeat (m - 1) @(negedge clk);
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        logic [53:0] c, start;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1234);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v);     check("R1 ctrl", v, 0);
        rd(A_IRQ_RAW, v);  check("R1 raw", v, 0);
        rd(A_IRQ_STAT, v); check("R1 stat", v, 0);
        check("R1 irq", irq, 0);
        get_count(c);      check("R1 count", c, 0);

        // R4 staging has no effect until trigger; R2 high word width
        wr(A_STG_LO, 32'h1234_5678);
        wr(A_STG_HI, 32'hFFFF_FFFF);
        get_count(c);      check("R4 staged-only", c, 0);
        wr(A_LOAD, 32'h0);
        get_count(c);      check("R4 load", c, {22'h3FFFFF, 32'h1234_5678});
        rd(A_CAP_HI, v);   check("R2 hi upper zero", v, 32'h003F_FFFF);

        // R6 wrap in both directions
        load(MAX54);
        run_for(ctrl(1, 1, 0, 0, 16'd1), 3);
        get_count(c);      check("R6 up wrap", c, 54'd2);
        load(54'd1);
        run_for(ctrl(1, 0, 0, 0, 16'd1), 3);
        get_count(c);      check("R6 down wrap", c, MAX54 - 54'd1);

        // R3 capture while running, stable until the next trigger
        load(54'd100);
        wr(A_CTRL, ctrl(1, 1, 0, 0, 16'd1));
        wr(A_CAP_TRIG, 32'h0);
        rd(A_CAP_LO, v);   check("R3 capture", v, 100);
        repeat (10) @(negedge clk);
        rd(A_CAP_LO, v2);  check("R3 capture stable", v2, 100);
        wr(A_CAP_TRIG, 32'h0);
        rd(A_CAP_LO, v);   check("R3 recapture", v, 111);
        wr(A_CTRL, 32'h0);

        // R11 hold while stopped
        get_count(start);
        repeat (20) @(negedge clk);
        get_count(c);      check("R11 hold", c, start);

        // R5 prescaler
        load(54'd0);
        run_for(ctrl(1, 1, 0, 0, 16'd4), 19);
        get_count(c);      check("R5 div4", c, exp_count(0, 1, 19, 4));
        load(54'd0);
        run_for(ctrl(1, 1, 0, 0, 16'd0), 100);
        get_count(c);      check("R5 div0 short", c, 0);
        load(54'd0);
        run_for(ctrl(1, 1, 0, 0, 16'd0), 65536);
        get_count(c);      check("R5 div0 full", c, 1);

        // random runs: R5 R6
        for (int i = 0; i < 16; i++) begin
            logic [53:0] st;
            bit up;
            int m, dv;
            st = {$urandom(), $urandom()};
            up = $urandom_range(0, 1);
            m  = $urandom_range(1, 60);
            dv = $urandom_range(1, 7);
            load(st);
            run_for(ctrl(1, up, 0, 0, 16'(dv)), m);
            get_count(c);
            check("R5 R6 random run", c, exp_count(st, up, m, dv));
        end

        // R8 disarmed target never fires
        load(54'd500);
        set_target(54'd400);
        wr(A_CTRL, ctrl(0, 1, 0, 0, 16'd1));
        repeat (5) @(negedge clk);
        rd(A_IRQ_RAW, v);  check("R8 disarmed", v, 0);

        // R7 passed target fires at once; R8 self-disarm; R10 gating
        wr(A_CTRL, ctrl(0, 1, 0, 1, 16'd1));
        @(negedge clk);
        rd(A_IRQ_RAW, v);  check("R7 passed up", v, 1);
        rd(A_CTRL, v);     check("R8 arm cleared", v[3], 0);
        rd(A_IRQ_STAT, v); check("R10 stat masked", v, 0);
        check("R10 irq masked", irq, 0);
        wr(A_IRQ_EN, 32'h1);
        check("R10 irq on", irq, 1);
        rd(A_IRQ_STAT, v); check("R10 stat on", v, 1);
        wr(A_IRQ_CLR, 32'h1);
        check("R10 w1c", irq, 0);
        rd(A_IRQ_RAW, v);  check("R10 raw cleared", v, 0);

        // R7 equality counting up
        load(54'd10);
        set_target(54'd10);
        wr(A_CTRL, ctrl(0, 1, 0, 1, 16'd1));
        @(negedge clk);
        rd(A_IRQ_RAW, v);  check("R7 equal", v, 1);
        wr(A_IRQ_CLR, 32'h1);

        // R7 down direction
        load(54'd500);
        set_target(54'd400);
        wr(A_CTRL, ctrl(0, 0, 0, 1, 16'd1));
        repeat (5) @(negedge clk);
        rd(A_IRQ_RAW, v);  check("R7 down not reached", v, 0);
        rd(A_CTRL, v);     check("R7 down still armed", v[3], 1);
        set_target(54'd600);
        @(negedge clk);
        rd(A_IRQ_RAW, v);  check("R7 down passed", v, 1);
        wr(A_CTRL, 32'h0);
        wr(A_IRQ_CLR, 32'h1);

        // running alarm without reload
        load(54'd0);
        set_target(54'd10);
        run_for(ctrl(1, 1, 0, 1, 16'd1), 20);
        rd(A_IRQ_RAW, v);  check("R7 running reach", v, 1);
        get_count(c);      check("R9 no reload", c, 20);
        wr(A_IRQ_CLR, 32'h1);

        // R9 auto-reload: match at count 10 reloads 3, then resumes
        load(54'd0);
        wr(A_STG_LO, 32'd3);
        wr(A_STG_HI, 32'd0);
        run_for(ctrl(1, 1, 1, 1, 16'd1), 20);
        rd(A_IRQ_RAW, v);  check("R9 reload fired", v, 1);
        get_count(c);      check("R9 reload count", c, 3 + (20 - 11));
        wr(A_IRQ_CLR, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule